// File: doc/BRIEF.md
# Two-Common Multiplexed LCD Driver

This block produces the digital drive-level codes for a half-bias, two-common multiplexed LCD panel. There are 28 segment pins, and each one carries a segment for each common, which gives 56 segments in all. A segment pattern register is loaded one digit at a time, where a digit covers two neighbouring segment pins. A phase timer derives the frame timing from the reference clock. The block then presents a two-bit level code on every common pin and every segment pin. An analog stage outside the block turns each code into low, middle or high voltage.

The four highest segment pins form a group. At run time, this group can be switched as a whole to act as general-purpose outputs. In that mode a source flag picks what the pins show: either an alternate port register or the output latch. Two reset inputs are provided. A power-up clear restarts everything, including the frame timer. A system reset clears the pattern and the group mode and forces the segments off, while the commons keep running. A backup input pulls every pin to low level.

Top module: `lcd_mux2_drv`

## Requirements
- R1: A frame is four phases of CLK_HZ/(4*FRAME_HZ) clock cycles each (10 ms at 4.5 MHz and 100 Hz). The phases run in the order 0,1,2,3 and restart at phase 0, cycle 0 after a power-up clear.
- R2: Level codes are 00 low, 01 middle, 10 high. `com_code[1:0]` is common 1 and `com_code[3:2]` is common 2. Common 1 is high in phase 0, low in phase 2 and middle otherwise. Common 2 is high in phase 1, low in phase 3 and middle otherwise.
- R3: Segment pin i drives `seg_code[2i+1:2i]`. In each phase the active common is common 1 for phases 0 and 2 and common 2 for phases 1 and 3. A pin whose bit for the active common is 1 drives the level opposite to that common. A pin whose bit is 0 drives the same level as that common. A segment pin never drives middle.
- R4: A write with `wr_en` high stores `wr_data[2k]` (common 1) and `wr_data[2k+1]` (common 2) for pin 2*`wr_digit`+k, k in 0..1. The new value is visible after the clock edge that takes the write. Digit indices 14 and 15 change nothing.
- R5: While `rst` is high, every segment pin drives the off level (the same level as the active common), and the commons and the phase timer continue unchanged. A clock edge with `rst` high clears the whole pattern and returns pins 24..27 to LCD function.
- R6: While `por` is high, every segment pin drives the off level. A clock edge with `por` high clears the pattern, the group mode and the phase timer.
- R7: While `backup` is high, every common and segment code is 00. The stored pattern, the group mode and the timer are kept.
- R8: A clock edge with `gp_set` high and `gp_clr` low switches pins 24..27 to general-purpose mode, and the opposite combination switches them back. Both high, or both low, leaves the mode as it was. Pins 0..23 are never affected.
- R9: In general-purpose mode, pin 24+k drives 10 if the selected bit k is 1 and 00 if it is 0. The source is `gp_alt` when `gp_src_alt` is 1 and `gp_latch` when it is 0.
- R10: Digit writes to pins 24..27 made in general-purpose mode are stored, and they appear on the pins once the group returns to LCD function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-up clear, synchronous, active high |
| rst | input | 1 | System reset, synchronous, active high |
| backup | input | 1 | Backup mode, forces all outputs low |
| wr_en | input | 1 | Digit write strobe |
| wr_digit | input | 4 | Digit index (two pins per digit) |
| wr_data | input | 4 | Segment bits for the two pins of the digit |
| gp_set | input | 1 | Switch pin group 24..27 to general-purpose mode |
| gp_clr | input | 1 | Return pin group 24..27 to LCD function |
| gp_src_alt | input | 1 | General-purpose source select: 1 alternate register, 0 latch |
| gp_alt | input | 4 | Alternate port register value |
| gp_latch | input | 4 | Output latch value |
| com_code | output | 4 | Level codes of the two commons |
| seg_code | output | 56 | Level codes of the 28 segment pins |

## Verification
The bench steps every digit through all sixteen data values, including the unused indices 14 and 15. If the decoder wrapped those indices, low pins would change without any write to them. It sweeps every value of both general-purpose sources in both select states. It also checks that a simultaneous set and clear leaves the mode alone, because a design that gave one of them priority would flip the group. Reset is applied in the middle of a frame to show that the commons keep their place and that the pattern and the mode come back cleared. Backup is applied with a pattern loaded, to show that the outputs come back intact after it ends. A power-up clear in mid-run must restart the frame at phase 0.

// File: rtl/lcd_mux2_pkg.sv
`timescale 1ns/1ps
package lcd_mux2_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    // phase 0 = {0,0}, 1 = {0,1}, 2 = {1,0}, 3 = {1,1}
    typedef struct packed {
        logic neg;   // active common drives low
        logic sel;   // 0: common 1 active, 1: common 2 active
    } phase_t;

    typedef struct packed {
        logic c2;
        logic c1;
    } segpair_t;

    function automatic lvl_e active_level(phase_t ph);
        return ph.neg ? LVL_LOW : LVL_HIGH;
    endfunction

    function automatic lvl_e com_level(phase_t ph, logic which);
        if (ph.sel != which) return LVL_MID;
        return active_level(ph);
    endfunction

    function automatic lvl_e seg_level(phase_t ph, logic on);
        if (on) return ph.neg ? LVL_HIGH : LVL_LOW;
        return active_level(ph);
    endfunction

    function automatic logic pick_bit(segpair_t p, phase_t ph);
        return ph.sel ? p.c2 : p.c1;
    endfunction

    function automatic lvl_e gp_level(logic b);
        return b ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
`timescale 1ns/1ps
module lcd_frame_timer
    import lcd_mux2_pkg::*;
#(
    parameter int PHASE_CYC = 11250,
    parameter int CW        = 14
) (
    input  logic          clk,
    input  logic          por,
    output phase_t        phase,
    output logic [CW-1:0] cyc
);

    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    always_ff @(posedge clk) begin
        if (por) begin
            cyc   <= '0;
            phase <= '0;
        end else if (cyc == LAST) begin
            cyc   <= '0;
            phase <= phase_t'(phase + 2'd1);
        end else begin
            cyc   <= cyc + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_seg_store.sv
`timescale 1ns/1ps
module lcd_seg_store
    import lcd_mux2_pkg::*;
#(
    parameter int N_PINS     = 28,
    parameter int DIGIT_PINS = 2,
    parameter int AW         = 4
) (
    input  logic                    clk,
    input  logic                    por,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_digit,
    input  logic [2*DIGIT_PINS-1:0] wr_data,
    input  logic                    gp_set,
    input  logic                    gp_clr,
    output segpair_t [N_PINS-1:0]   pat,
    output logic                    grp_gp
);

    localparam int N_DIGITS = N_PINS / DIGIT_PINS;

    always_ff @(posedge clk) begin
        if (por || rst) begin
            pat    <= '0;
            grp_gp <= 1'b0;
        end else begin
            if (wr_en) begin
                for (int d = 0; d < N_DIGITS; d++) begin
                    if (wr_digit == AW'(d)) begin
                        for (int k = 0; k < DIGIT_PINS; k++) begin
                            pat[d*DIGIT_PINS + k] <= segpair_t'(wr_data[2*k +: 2]);
                        end
                    end
                end
            end
            if (gp_set && !gp_clr) begin
                grp_gp <= 1'b1;
            end else if (gp_clr && !gp_set) begin
                grp_gp <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lcd_pin_mux.sv
`timescale 1ns/1ps
module lcd_pin_mux
    import lcd_mux2_pkg::*;
#(
    parameter int N_PINS = 28,
    parameter int N_GP   = 4
) (
    input  phase_t                phase,
    input  segpair_t [N_PINS-1:0] pat,
    input  logic                  grp_gp,
    input  logic                  src_alt,
    input  logic [N_GP-1:0]       gp_alt,
    input  logic [N_GP-1:0]       gp_latch,
    input  logic                  force_off,
    input  logic                  blank,
    output logic [3:0]            com_code,
    output logic [2*N_PINS-1:0]   seg_code
);

    localparam int GP_BASE = N_PINS - N_GP;

    logic [N_GP-1:0] gp_src;
    assign gp_src = src_alt ? gp_alt : gp_latch;

    assign com_code[1:0] = blank ? LVL_LOW : com_level(phase, 1'b0);
    assign com_code[3:2] = blank ? LVL_LOW : com_level(phase, 1'b1);

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        lvl_e lcd_lvl;
        assign lcd_lvl = force_off ? seg_level(phase, 1'b0)
                                   : seg_level(phase, pick_bit(pat[i], phase));
        if (i < GP_BASE) begin : g_lcd
            assign seg_code[2*i +: 2] = blank ? LVL_LOW : lcd_lvl;
        end else begin : g_shared
            assign seg_code[2*i +: 2] = blank  ? LVL_LOW :
                                        (grp_gp && !force_off) ? gp_level(gp_src[i-GP_BASE])
                                                               : lcd_lvl;
        end
    end

endmodule

// File: rtl/lcd_mux2_drv.sv
`timescale 1ns/1ps
module lcd_mux2_drv
    import lcd_mux2_pkg::*;
#(
    parameter int CLK_HZ     = 4500000,
    parameter int FRAME_HZ   = 100,
    parameter int N_SEG_PINS = 28,
    parameter int DIGIT_PINS = 2,
    parameter int N_GP       = 4
) (
    input  logic                                       clk,
    input  logic                                       por,
    input  logic                                       rst,
    input  logic                                       backup,
    input  logic                                       wr_en,
    input  logic [$clog2(N_SEG_PINS/DIGIT_PINS+1)-1:0] wr_digit,
    input  logic [2*DIGIT_PINS-1:0]                    wr_data,
    input  logic                                       gp_set,
    input  logic                                       gp_clr,
    input  logic                                       gp_src_alt,
    input  logic [N_GP-1:0]                            gp_alt,
    input  logic [N_GP-1:0]                            gp_latch,
    output logic [3:0]                                 com_code,
    output logic [2*N_SEG_PINS-1:0]                    seg_code
);

    localparam int PHASE_CYC = CLK_HZ / (4 * FRAME_HZ);
    localparam int CW        = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam int AW        = $clog2(N_SEG_PINS/DIGIT_PINS + 1);

    phase_t                    phase;
    logic [CW-1:0]             tmr_cyc;
    segpair_t [N_SEG_PINS-1:0] pat;
    logic                      grp_gp;

    lcd_frame_timer #(.PHASE_CYC(PHASE_CYC), .CW(CW)) u_tmr (
        .clk   (clk),
        .por   (por),
        .phase (phase),
        .cyc   (tmr_cyc)
    );

    lcd_seg_store #(.N_PINS(N_SEG_PINS), .DIGIT_PINS(DIGIT_PINS), .AW(AW)) u_store (
        .clk      (clk),
        .por      (por),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_digit (wr_digit),
        .wr_data  (wr_data),
        .gp_set   (gp_set),
        .gp_clr   (gp_clr),
        .pat      (pat),
        .grp_gp   (grp_gp)
    );

    lcd_pin_mux #(.N_PINS(N_SEG_PINS), .N_GP(N_GP)) u_mux (
        .phase     (phase),
        .pat       (pat),
        .grp_gp    (grp_gp),
        .src_alt   (gp_src_alt),
        .gp_alt    (gp_alt),
        .gp_latch  (gp_latch),
        .force_off (rst | por),
        .blank     (backup),
        .com_code  (com_code),
        .seg_code  (seg_code)
    );

endmodule

// File: rtl/lcd_mux2_chk.sv
`timescale 1ns/1ps
module lcd_mux2_chk #(
    parameter int N_PINS    = 28,
    parameter int PHASE_CYC = 11250,
    parameter int CW        = 14
) (
    input logic                clk,
    input logic                por,
    input logic                rst,
    input logic                backup,
    input logic                gp_set,
    input logic                gp_clr,
    input logic [3:0]          com_code,
    input logic [2*N_PINS-1:0] seg_code,
    input logic [CW-1:0]       cyc,
    input logic                grp_gp
);

    localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

    assert_backup_low_R7: assert property (@(posedge clk) disable iff (por)
        backup |-> (com_code == '0 && seg_code == '0));

    assert_one_common_active_R2: assert property (@(posedge clk) disable iff (por)
        !backup |-> ((com_code[1:0] == 2'b01) != (com_code[3:2] == 2'b01)));

    assert_phase_hold_R1: assert property (@(posedge clk) disable iff (por)
        (!backup && cyc != LAST) |=> (backup || $stable(com_code)));

    assert_rst_seg_off_R5: assert property (@(posedge clk) disable iff (por)
        (rst && !backup) |->
        (seg_code[1:0] == ((com_code[1:0] != 2'b01) ? com_code[1:0] : com_code[3:2])));

    assert_seg_no_mid_R3: assert property (@(posedge clk) disable iff (por)
        (seg_code[0] == 1'b0) && (seg_code[2*N_PINS-2] == 1'b0));

    assert_gp_enter_R8: assert property (@(posedge clk) disable iff (por)
        (gp_set && !gp_clr && !rst) |=> grp_gp);

    assert_gp_leave_R8: assert property (@(posedge clk) disable iff (por)
        (gp_clr && !gp_set) |=> !grp_gp);

endmodule

bind lcd_mux2_drv lcd_mux2_chk #(
    .N_PINS(N_SEG_PINS), .PHASE_CYC(PHASE_CYC), .CW(CW)
) u_chk (
    .clk(clk), .por(por), .rst(rst), .backup(backup),
    .gp_set(gp_set), .gp_clr(gp_clr),
    .com_code(com_code), .seg_code(seg_code),
    .cyc(tmr_cyc), .grp_gp(grp_gp)
);

// File: tb/sim_lcd_mux2_drv.sv
`timescale 1ns/1ps
module sim_lcd_mux2_drv;

    localparam int NP = 28;
    localparam int PC = 4;      // 400 Hz clock / (4 * 25 Hz)

    logic clk = 1'b0;
    logic por = 1'b1, rst = 1'b0, backup = 1'b0;
    logic wr_en = 1'b0, gp_set = 1'b0, gp_clr = 1'b0, gp_src_alt = 1'b0;
    logic [3:0] wr_digit = '0, wr_data = '0, gp_alt = '0, gp_latch = '0;
    logic [3:0] com_code;
    logic [2*NP-1:0] seg_code;

    always #2.5 clk = ~clk;

    lcd_mux2_drv #(.CLK_HZ(400), .FRAME_HZ(25)) u0 (
        .clk(clk), .por(por), .rst(rst), .backup(backup),
        .wr_en(wr_en), .wr_digit(wr_digit), .wr_data(wr_data),
        .gp_set(gp_set), .gp_clr(gp_clr), .gp_src_alt(gp_src_alt),
        .gp_alt(gp_alt), .gp_latch(gp_latch),
        .com_code(com_code), .seg_code(seg_code)
    );

    // reference model
    int         tcount = 0;
    logic [1:0] m_pat [NP];
    logic       m_gp = 1'b0;
    int         n_chk = 0, n_bad = 0, cycles = 0;
    logic       chk_en = 1'b0, done = 1'b0;
    string      cur_req = "R6";

    always @(posedge clk) begin
        if (por) begin
            tcount <= 0;
            for (int i = 0; i < NP; i++) m_pat[i] <= 2'b00;
            m_gp <= 1'b0;
        end else begin
            tcount <= tcount + 1;
            if (rst) begin
                for (int i = 0; i < NP; i++) m_pat[i] <= 2'b00;
                m_gp <= 1'b0;
            end else begin
                if (wr_en && int'(wr_digit) < NP/2) begin
                    m_pat[2*wr_digit]   <= wr_data[1:0];
                    m_pat[2*wr_digit+1] <= wr_data[3:2];
                end
                if (gp_set && !gp_clr) m_gp <= 1'b1;
                else if (gp_clr && !gp_set) m_gp <= 1'b0;
            end
        end
    end

    function automatic int ph();
        return (tcount / PC) % 4;
    endfunction

    function automatic logic [1:0] act_lvl();
        return (ph() >= 2) ? 2'b00 : 2'b10;
    endfunction

    function automatic logic [3:0] exp_com();
        logic [3:0] r;
        for (int c = 0; c < 2; c++)
            r[2*c +: 2] = backup ? 2'b00 : ((ph() % 2) != c) ? 2'b01 : act_lvl();
        return r;
    endfunction

    function automatic logic [2*NP-1:0] exp_seg();
        logic [2*NP-1:0] r;
        for (int i = 0; i < NP; i++) begin
            logic on;
            logic [3:0] src;
            src = gp_src_alt ? gp_alt : gp_latch;
            on  = m_pat[i][ph() % 2];
            if (backup)                  r[2*i +: 2] = 2'b00;
            else if (rst || por)         r[2*i +: 2] = act_lvl();
            else if (m_gp && i >= NP-4)  r[2*i +: 2] = src[i-(NP-4)] ? 2'b10 : 2'b00;
            else if (on)                 r[2*i +: 2] = ~act_lvl() & 2'b10;
            else                         r[2*i +: 2] = act_lvl();
        end
        return r;
    endfunction

    function automatic string cond_tag();
        if (backup) return "R7";
        if (por)    return "R6";
        if (rst)    return "R5";
        if (m_gp)   return "R9";
        return "R3";
    endfunction

    always @(negedge clk) begin : g_check
        logic [3:0]      ec;
        logic [2*NP-1:0] es;
        if (chk_en && !done) begin
            ec = exp_com();
            es = exp_seg();
            n_chk += 2;
            if (com_code !== ec) begin
                n_bad++;
                $display("FAIL %s/R2 com_code actual=%b expected=%b t=%0d", cur_req, com_code, ec, tcount);
            end
            if (seg_code !== es) begin
                n_bad++;
                $display("FAIL %s/%s seg_code actual=%h expected=%h t=%0d", cur_req, cond_tag(), seg_code, es, tcount);
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(int d, logic [3:0] v);
        wr_en = 1'b1; wr_digit = 4'(d); wr_data = v;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic gp_cmd(logic s, logic c);
        gp_set = s; gp_clr = c;
        tick(1);
        gp_set = 1'b0; gp_clr = 1'b0;
    endtask

    initial begin
        tick(2);
        chk_en = 1'b1;
        cur_req = "R6";              // power-up clear held: segments off, timer at 0
        tick(3);
        por = 1'b0;
        cur_req = "R1";              // blank pattern, three full frames
        tick(3*4*PC);
        cur_req = "R4";              // near-exhaustive digit sweep incl. indices 14, 15
        for (int d = 0; d < 16; d++)
            for (int v = 0; v < 16; v++) begin
                wr(d, 4'(v));
                tick(1);
            end
        for (int d = 0; d < 16; d++) wr(d, 4'((d*7 + 5) & 15));
        cur_req = "R3";
        tick(2*4*PC);
        cur_req = "R8";              // enter general-purpose mode
        gp_cmd(1'b1, 1'b0);
        tick(2);
        cur_req = "R9";              // both sources, all values
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++) begin
                gp_src_alt = s[0]; gp_alt = 4'(a); gp_latch = 4'(15 - a);
                tick(1);
            end
        cur_req = "R8";              // set and clear together: no change
        gp_cmd(1'b1, 1'b1);
        tick(3);
        cur_req = "R10";             // writes to shared pins while in GP mode
        wr(12, 4'b1001);
        wr(13, 4'b0110);
        tick(2);
        gp_cmd(1'b0, 1'b1);
        tick(4*PC);
        cur_req = "R8";
        gp_cmd(1'b1, 1'b1);
        tick(2);
        gp_cmd(1'b1, 1'b0);
        tick(2);
        cur_req = "R5";              // system reset mid-frame
        tick(1);
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(4*PC);
        for (int d = 0; d < 14; d++) wr(d, 4'(15 - d));
        cur_req = "R7";              // backup with a loaded pattern
        backup = 1'b1;
        tick(4*PC + 3);
        backup = 1'b0;
        tick(4*PC);
        cur_req = "R6";              // power-up clear mid-run restarts the frame
        tick(3);
        por = 1'b1;
        tick(2);
        por = 1'b0;
        tick(4*PC + 2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule